// File: doc/BRIEF.md
# Word-Addressed Data Memory with Range Fault

This block is a small data store of 64-bit words that serves exactly one access per clock cycle: a read or a write. The address selects a word. A read is purely combinational, so the selected word appears on the read-data output in the same cycle that the address and read strobe are presented. A write is registered and lands in the array at the next rising clock edge.

Any request that the array cannot honour raises a combinational fault flag during that cycle, and the array is then left untouched. There are two such cases: an address at or beyond the implemented depth, or read and write strobes raised together. The implemented depth is a parameter and the address port may be wider than the depth needs. An address is therefore compared in full against the depth and never folded back onto a lower word. An asynchronous active-low reset clears every word to zero.

Top module: `dmem_core`

## Requirements
- R1: After reset every implemented word reads back as zero.
- R2: With read strobe high, write strobe low and address below DEPTH, rd_data equals the stored word in the same cycle, and err is 0.
- R3: With write strobe high, read strobe low and address below DEPTH, wr_data is stored into that word at the rising clock edge, err is 0 and no other word changes.
- R4: When exactly one strobe is high and the address is DEPTH or above, err is 1 in that cycle.
- R5: A write whose address is DEPTH or above changes no word, including the word whose index equals the low address bits.
- R6: A read whose address is DEPTH or above drives rd_data to all zeros.
- R7: When read and write strobes are both high, err is 1, rd_data is all zeros and no word changes, whatever the address.
- R8: When neither strobe is high, err is 0, rd_data is all zeros and no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the array |
| addr | input | ADDR_W | Word address of the access |
| wr_data | input | WORD_W | Word to be written |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | WORD_W | Word read, zero unless a valid read |
| err | output | 1 | Fault flag for an out-of-range or conflicting access |

## Verification
A wrong access classification shows up in the same cycle as a wrong err or rd_data value. A stray or missing write stays hidden until the affected word is next read, and that read can come many cycles later. For this reason the bench reads the whole array back after every phase of writes, faulty writes, conflicting strobes and idle cycles. The address sweep covers every value of a 5-bit address against a depth of 12. This catches masking of the address or folding of out-of-range addresses onto a lower word.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_CLASH = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      in_range;
        logic      fault;
        logic      rd_ok;
        logic      wr_ok;
    } acc_info_t;

endpackage

// File: rtl/dmem_access_decode.sv
module dmem_access_decode
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DEPTH  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output acc_info_t         info
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    always_comb begin
        info          = '0;
        info.in_range = ({1'b0, addr} < LIMIT);
        unique case ({rd_en, wr_en})
            2'b10:   info.kind = ACC_READ;
            2'b01:   info.kind = ACC_WRITE;
            2'b11:   info.kind = ACC_CLASH;
            default: info.kind = ACC_IDLE;
        endcase
        info.fault = (info.kind == ACC_CLASH) ||
                     ((info.kind != ACC_IDLE) && !info.in_range);
        info.rd_ok = (info.kind == ACC_READ)  && info.in_range;
        info.wr_ok = (info.kind == ACC_WRITE) && info.in_range;
    end

endmodule

// File: rtl/dmem_word_bank.sv
module dmem_word_bank #(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 12,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              rd_ok,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] words;
    } bank_state_t;

    bank_state_t       st_d;
    bank_state_t       st_q;
    logic [DEPTH-1:0]  wr_sel;

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign wr_sel[i] = wr_ok && (idx == IDX_W'(i));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_sel[i]) begin
                st_d.words[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            rdata = st_q.words[idx];
        end
    end

    // at most one word is targeted per cycle (R3)
    p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        // a selected word holds the written data after the edge (R3)
        p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel[i] |=> (st_q.words[i] == $past(wdata)));
        // an unselected word never moves (R5, R7, R8)
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel[i] |=> $stable(st_q.words[i]));
    end

endmodule

// File: rtl/dmem_core.sv
module dmem_core
    import dmem_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 12,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              err
);

    localparam int              IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    acc_info_t info;

    dmem_access_decode #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_decode (
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .info  (info)
    );

    dmem_word_bank #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (info.wr_ok),
        .rd_ok (info.rd_ok),
        .idx   (addr[IDX_W-1:0]),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    assign err = info.fault;

    // in-range single read reports no fault (R2)
    p_read_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && ({1'b0, addr} < LIMIT)) |-> !err);
    // single strobe beyond depth raises the fault (R4)
    p_range_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en != wr_en) && ({1'b0, addr} >= LIMIT)) |-> err);
    // any faulted cycle drives zero data (R6)
    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd_data == '0));
    // both strobes together are always a fault (R7)
    p_clash_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> err);
    // idle cycle is quiet on both outputs (R8)
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |-> (!err && (rd_data == '0)));

endmodule

// File: tb/dmem_core_tb.sv
`timescale 1ns/1ps
module dmem_core_tb_top;

    localparam int WORD_W = 64;
    localparam int DEPTH  = 12;
    localparam int ADDR_W = 5;
    localparam int NADDR  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [WORD_W-1:0] rd_data;
    logic              err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [WORD_W-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    dmem_core #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .rd_data (rd_data),
        .err     (err)
    );

    function automatic logic [WORD_W-1:0] pat(input int a, input int k);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(a + 1)) ^ (64'(k) << 40) ^ 64'(k * 977);
    endfunction

    task automatic check(input string tag, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one access cycle: drive at negedge, sample 1 ns later, commit at posedge
    task automatic access(input logic rd, input logic wr, input int a,
                          input logic [WORD_W-1:0] d, input string tag);
        logic in_rng;
        logic exp_err;
        logic [WORD_W-1:0] exp_rd;
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = ADDR_W'(a); wr_data = d;
        in_rng  = (a < DEPTH);
        exp_err = (rd && wr) || ((rd || wr) && !in_rng);
        exp_rd  = (rd && !wr && in_rng) ? model[a] : '0;
        #1;
        check({tag, " err"}, {63'd0, err}, {63'd0, exp_err});
        check({tag, " rd_data"}, rd_data, exp_rd);
        @(posedge clk);
        if (wr && !rd && in_rng) model[a] = d;
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < DEPTH; a++) access(1'b1, 1'b0, a, '1, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared array
        read_all("R1 reset readback");

        // R3: fill every word, then R2 read back
        for (int a = 0; a < DEPTH; a++) access(1'b0, 1'b1, a, pat(a, 1), "R3 write");
        read_all("R2 read after fill");

        // R4/R6: full address sweep with reads
        for (int a = 0; a < NADDR; a++)
            access(1'b1, 1'b0, a, '0, (a < DEPTH) ? "R2 sweep read" : "R4 R6 range read");

        // R4/R5: writes beyond depth must not alias
        for (int a = DEPTH; a < NADDR; a++) access(1'b0, 1'b1, a, pat(a, 7), "R4 range write");
        read_all("R5 readback after range writes");

        // R7: both strobes on every address
        for (int a = 0; a < NADDR; a++) access(1'b1, 1'b1, a, pat(a, 9), "R7 clash");
        read_all("R7 readback after clash");

        // R8: idle cycles with garbage data
        for (int a = 0; a < NADDR; a++) access(1'b0, 1'b0, a, pat(a, 11), "R8 idle");
        read_all("R8 readback after idle");

        // R3: overwrite alternate words, neighbours untouched
        for (int a = 0; a < DEPTH; a += 2) access(1'b0, 1'b1, a, pat(a, 21), "R3 overwrite");
        access(1'b0, 1'b1, DEPTH - 1, '1, "R3 top word");
        access(1'b0, 1'b1, 0, '0, "R3 zero word");
        read_all("R3 readback after overwrite");

        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule